// File: doc/BRIEF.md
# Serial Configuration Stream Loader

This block receives a configuration bitstream one bit per configuration clock. It waits out an idle run of ones and locks on when it sees a 4-bit preamble. It then takes a 24-bit length count and reads a fixed number of frames. Each frame has a start marker, a data word and a check field. The block writes each accepted frame word to a memory write port, with the frame's index as the address. The storage behind that port lies outside the block.

A second output feeds the next device in a daisy chain. In serial chain mode it passes on the header and then stays high while this device's frames arrive. Once every local frame has loaded, it forwards the stream again. In express mode the length count plays no part. The chain output then acts as an enable for the next device: it stays low until this device is programmed and goes high afterwards.

A bad check field stops loading and raises a sticky error. One bit near the start of the first frame asks for an eight-times-faster configuration clock. It is presented on its own output, which reads low (the slow rate) until that bit has arrived.

Top module: `cfg_stream_loader`

## Requirements
- R1: Ones before the preamble are ignored. The header starts only after the four consecutive bits 0, 0, 1, 0, received in that order.
- R2: The 24 bits after the preamble are a length count, sent MSB first. In serial mode, `done` is high only when two conditions hold: all frames have loaded, and the number of bits received since the first preamble bit is at least the length count plus 4. From then on, `done` stays high.
- R3: In serial mode, `dout` shows the previous clock's `din` while the block is idle, during the preamble and during the length count. `dout` is 1 from the first bit after the length count through the last check bit of the final frame. After that, `dout` shows the previous clock's `din` again.
- R4: After the length count, extra 1 bits before any frame are skipped. A frame is one 0 start bit, then FRAME_BITS data bits (MSB first), then the 4-bit check field 0110. For each accepted frame, `wr_en` pulses for one clock, starting one clock after the last check bit. During that pulse, `wr_data` holds the word and `wr_addr` holds the frame index; indices run from 0 in arrival order.
- R5: If a check field differs from 0110, `err` goes high one clock after the last check bit and stays high until reset. After that, no write occurs, `done` stays low and `dout` holds its level: 1 in serial mode, 0 in express mode.
- R6: In express mode the length count has no effect. `dout` is 0 until the final frame's check field has been accepted, then 1. `done` rises on the same clock.
- R7: `fast_clk` is 0 after reset. Once data bit number FAST_POS of frame 0 has been received (bits numbered from 0 at the first data bit), `fast_clk` takes that bit's value. It does not change again before reset.
- R8: After reset, `err`, `done`, `wr_en` and `fast_clk` are 0. `dout` is 1 in serial mode and 0 in express mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; one stream bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial stream input |
| express | input | 1 | 1 selects express chain mode, 0 selects serial chain mode; change only during reset |
| dout | output | 1 | Chain output to the next device |
| wr_en | output | 1 | Frame word write strobe |
| wr_addr | output | $clog2(FRAME_COUNT) | Index of the frame being written |
| wr_data | output | FRAME_BITS | Frame data word |
| err | output | 1 | Sticky frame check failure (drives init low externally) |
| done | output | 1 | Configuration complete |
| fast_clk | output | 1 | Request for the eight-times configuration clock |

## Verification
The assertions check four things on every clock: the error flag stays set once raised, writes never occur alongside it, write pulses are never back to back, and the fast-clock request is frozen outside the header and data phases. They also check that serial `dout` is high while frame data and check bits arrive. Only the bench's scenarios can show the rest: the exact clock on which `done` rises against the captured length, that preamble look-alikes in the idle run are rejected, that forwarding starts on the right bit, and that words and addresses appear in order. The bench sweeps both chain modes, several dummy-field lengths, several length surpluses and both fast-bit values. It also injects a check failure into each frame.

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader #(
  parameter int FRAME_BITS  = 8,
  parameter int FRAME_COUNT = 4,
  parameter int LEN_BITS    = 24,
  parameter int FAST_POS    = 1,
  parameter logic [3:0] CHECK = 4'b0110
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  din,
  input  logic                  express,
  output logic                  dout,
  output logic                  wr_en,
  output logic [((FRAME_COUNT>1)?$clog2(FRAME_COUNT):1)-1:0] wr_addr,
  output logic [FRAME_BITS-1:0] wr_data,
  output logic                  err,
  output logic                  done,
  output logic                  fast_clk
);
  localparam int AW   = (FRAME_COUNT > 1) ? $clog2(FRAME_COUNT) : 1;
  localparam int CW   = LEN_BITS + 2;
  localparam int MAXB = (LEN_BITS > FRAME_BITS) ? LEN_BITS : FRAME_BITS;
  localparam int BW   = $clog2(MAXB + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_SYNC, S_DATA, S_CHK, S_PASS, S_ERR} state_t;

  state_t                state;
  logic [3:0]            pre_sr;
  logic [LEN_BITS-1:0]   len_q;
  logic [CW-1:0]         cnt_q;
  logic [BW-1:0]         bit_q;
  logic [AW-1:0]         frame_q;
  logic [FRAME_BITS-1:0] data_q;
  logic [2:0]            chk_q;
  logic [AW-1:0]         addr_q;
  logic                  fwd_q, wr_q, fast_q;

  wire pre_hit  = ({pre_sr[2:0], din} == 4'b0010);
  wire len_met  = (cnt_q >= ({2'b00, len_q} + CW'(4)));
  wire forward  = (state == S_IDLE) || (state == S_HDR) || (state == S_PASS);

  assign dout     = express ? (state == S_PASS) : fwd_q;
  assign done     = (state == S_PASS) && (express || len_met);
  assign err      = (state == S_ERR);
  assign wr_en    = wr_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign fast_clk = fast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pre_sr  <= 4'hF;
      len_q   <= '0;
      cnt_q   <= '0;
      bit_q   <= '0;
      frame_q <= '0;
      data_q  <= '0;
      chk_q   <= '0;
      addr_q  <= '0;
      fwd_q   <= 1'b1;
      wr_q    <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      wr_q  <= 1'b0;
      fwd_q <= forward ? din : 1'b1;
      if (state != S_IDLE && cnt_q != '1) cnt_q <= cnt_q + CW'(1);
      case (state)
        S_IDLE: begin
          pre_sr <= {pre_sr[2:0], din};
          if (pre_hit) begin
            state <= S_HDR;
            bit_q <= '0;
            cnt_q <= CW'(4);
          end
        end
        S_HDR: begin
          len_q <= {len_q[LEN_BITS-2:0], din};
          bit_q <= bit_q + BW'(1);
          if (bit_q == BW'(LEN_BITS - 1)) state <= S_SYNC;
        end
        S_SYNC: begin
          if (!din) begin
            state <= S_DATA;
            bit_q <= '0;
          end
        end
        S_DATA: begin
          data_q <= {data_q[FRAME_BITS-2:0], din};
          if (frame_q == '0 && bit_q == BW'(FAST_POS)) fast_q <= din;
          bit_q <= bit_q + BW'(1);
          if (bit_q == BW'(FRAME_BITS - 1)) begin
            state <= S_CHK;
            bit_q <= '0;
          end
        end
        S_CHK: begin
          chk_q <= {chk_q[1:0], din};
          bit_q <= bit_q + BW'(1);
          if (bit_q == BW'(3)) begin
            if ({chk_q, din} == CHECK) begin
              wr_q   <= 1'b1;
              addr_q <= frame_q;
              if (frame_q == AW'(FRAME_COUNT - 1)) state <= S_PASS;
              else begin
                state   <= S_SYNC;
                frame_q <= frame_q + AW'(1);
              end
            end else begin
              state <= S_ERR;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_no_write_in_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_en);
  assert_write_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_serial_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!express && (state == S_DATA || state == S_CHK)) |-> dout);
  assert_fast_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && state != S_HDR && state != S_DATA) |=> $stable(fast_clk));
endmodule

// File: tb/cfg_stream_loader_test.sv
module cfg_stream_loader_test;
  localparam int FB = 8;
  localparam int FC = 4;
  localparam int FP = 1;

  logic clk = 1'b0, rst_n = 1'b0, din = 1'b1, express = 1'b0;
  logic dout, wr_en, err, done, fast_clk;
  logic [1:0] wr_addr;
  logic [FB-1:0] wr_data;

  int checks = 0, fails = 0;
  int n, len, exp_addr;
  bit counting, loaded, exp_err, exp_fast, fwd, exp_wr;
  logic [FB-1:0] exp_data;

  cfg_stream_loader #(.FRAME_BITS(FB), .FRAME_COUNT(FC), .FAST_POS(FP)) uut (
    .clk(clk), .rst_n(rst_n), .din(din), .express(express), .dout(dout),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .err(err),
    .done(done), .fast_clk(fast_clk));

  always #5 clk = ~clk;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic send(bit b, string req);
    bit ed, ed_out;
    @(negedge clk);
    din = b;
    @(posedge clk);
    #1;
    if (counting) n++;
    if (express) ed_out = loaded && !exp_err;
    else ed_out = fwd ? b : 1'b1;
    ed = loaded && !exp_err && (express || n >= len + 4);
    check(dout === ed_out, req, "dout", int'(dout), int'(ed_out));
    check(done === ed, "R2", "done", int'(done), int'(ed));
    check(err === exp_err, "R5", "err", int'(err), int'(exp_err));
    check(fast_clk === exp_fast, "R7", "fast_clk", int'(fast_clk), int'(exp_fast));
    check(wr_en === exp_wr, "R4", "wr_en", int'(wr_en), int'(exp_wr));
    if (exp_wr && wr_en) begin
      check(wr_data === exp_data, "R4", "wr_data", int'(wr_data), int'(exp_data));
      check(int'(wr_addr) == exp_addr, "R4", "wr_addr", int'(wr_addr), exp_addr);
    end
    exp_wr = 1'b0;
  endtask

  task automatic run(bit xm, int dummies, int extra, int bad, int seed, bit fv);
    logic [FB-1:0] w;
    rst_n = 1'b0; express = xm; din = 1'b1;
    n = 0; counting = 0; loaded = 0; exp_err = 0; exp_fast = 0; exp_wr = 0;
    len = 4 + 24 + FC * (dummies + 1 + FB + 4) + extra;
    #12;
    check(err === 1'b0 && done === 1'b0 && wr_en === 1'b0 && fast_clk === 1'b0,
          "R8", "flags after reset", int'({err, done, wr_en, fast_clk}), 0);
    check(dout === !xm, "R8", "dout after reset", int'(dout), int'(!xm));
    rst_n = 1'b1;
    fwd = 1;
    send(1, "R1"); send(0, "R1"); send(0, "R1"); send(1, "R1"); send(1, "R1");
    send(0, "R1"); counting = 1; n = 1;
    send(0, "R1"); send(1, "R1"); send(0, "R1");
    for (int i = 23; i >= 0; i--) send(len[i], "R3");
    fwd = 0;
    for (int f = 0; f < FC; f++) begin
      for (int d = 0; d < dummies; d++) send(1, "R4");
      send(0, "R3");
      w = FB'(seed * 53 + f * 29 + 7);
      if (f == 0) w[FB-1-FP] = fv;
      for (int i = FB - 1; i >= 0; i--) begin
        if (f == 0 && (FB - 1 - i) == FP) exp_fast = w[i];
        send(w[i], "R3");
      end
      send(0, "R4"); send(1, "R4"); send(1, "R4");
      if (f == bad) begin
        exp_err = 1;
        send(1, "R5");
        break;
      end
      exp_wr = 1; exp_data = w; exp_addr = f;
      if (f == FC - 1) loaded = 1;
      send(0, xm ? "R6" : "R4");
    end
    fwd = (bad < 0);
    for (int t = 0; t < extra + 6; t++) send(((t * 3 + seed) % 5) < 2, xm ? "R6" : "R3");
    check(err === (bad >= 0), "R5", "final err", int'(err), int'(bad >= 0));
    if (bad < 0) check(fast_clk === fv, "R7", "final fast_clk", int'(fast_clk), int'(fv));
  endtask

  initial begin
    int seed = 0;
    for (int xm = 0; xm < 2; xm++)
      for (int dm = 0; dm < 3; dm++)
        for (int ex = 0; ex < 3; ex++)
          for (int fv = 0; fv < 2; fv++) begin
            run(xm[0], dm, ex, -1, seed, fv[0]);
            seed++;
          end
    for (int xm = 0; xm < 2; xm++)
      for (int bf = 0; bf < FC; bf++) begin
        run(xm[0], bf % 2, 1, bf, seed, 1'b1);
        seed++;
      end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL R8 watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule